// File: doc/BRIEF.md
# Four-Operand Carry-Save Adder

This combinational block adds four unsigned operands of `W` bits each and returns the exact total on `W+2` bits. The slow ripple-carry path is used only once. The first two steps are rows of independent 3:2 compressor cells, which have no carry chain between neighbouring columns. These rows reduce the four operands to one sum vector and one carry vector. A single carry-propagate adder then resolves those two vectors into the result.

The first compressor row takes operands `in_w`, `in_x` and `in_y`. The second row takes the first row's sum vector, the first row's carry vector moved up one bit position, and operand `in_z`. All internal vectors are `W+2` bits wide and zero-extended, so no carry weight is dropped at any step. The block is intended for places where several values must be added in one cycle, for example the partial-product reduction in a multiplier or the sum of several accumulators.

Top module: `csa_quad_adder`

## Requirements
- R1: `total` equals `in_w + in_x + in_y + in_z` exactly, as an unsigned value of `W+2` bits, for every combination of inputs.
- R2: Each compressor cell produces sum = XOR of its three input bits and carry = majority of its three input bits.
- R3: The first compressor row combines `in_w`, `in_x` and `in_y`. The second row combines the first row's sum vector, its shifted carry vector and `in_z`. Each operand therefore contributes to `total` with weight one.
- R4: A carry vector produced in bit column i carries weight 2^(i+1). It is shifted left by one position before the next row or the final adder uses it.
- R5: No carry is lost. The top bit of each carry vector and the carry-out of the final adder are always zero.
- R6: Exactly one carry-propagate adder is used, at the output. It adds the second row's sum vector to that row's shifted carry vector with a carry-in of zero.
- R7: With all four operands at their maximum value, `total` equals 4*(2^W - 1). For this case the top two bits of `total` are `11` and the lower `W` bits are all ones except bit 0 and bit 1, which are zero.
- R8: With all four operands zero, `total` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_w | input | W | First operand, unsigned |
| in_x | input | W | Second operand, unsigned |
| in_y | input | W | Third operand, unsigned |
| in_z | input | W | Fourth operand, added in the second compressor row |
| total | output | W+2 | Exact unsigned sum of the four operands |

## Verification
The bench builds the adder with `W = 4`. At this width all 65,536 operand combinations can be swept in one run. The sweep therefore covers every carry pattern in both compressor rows and every ripple length in the final adder. It also includes the all-zero and all-ones corners and each case where only one operand is nonzero. The expected total is computed in the bench as an integer sum.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Single-column 3:2 compression: sum bit
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // Single-column 3:2 compression: carry bit (majority)
  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (b & c) | (a & c);
  endfunction

endpackage

// File: rtl/csa_fa_cell.sv
module csa_fa_cell
  import csa_pkg::*;
(
  input  logic bit_a,
  input  logic bit_b,
  input  logic bit_c,
  output logic bit_s,
  output logic bit_co
);
  assign bit_s  = fa_sum(bit_a, bit_b, bit_c);
  assign bit_co = fa_carry(bit_a, bit_b, bit_c);

  // R2: two-bit count of the ones among the three inputs
  always_comb begin
    a_r2_cell_count: assert ({1'b0, bit_a} + {1'b0, bit_b} + {1'b0, bit_c}
                             == {bit_co, bit_s})
      else $error("R2 cell count mismatch");
  end
endmodule

// File: rtl/csa_row.sv
module csa_row #(
  parameter int X = 6
) (
  input  logic [X-1:0] in0,
  input  logic [X-1:0] in1,
  input  logic [X-1:0] in2,
  output logic [X-1:0] sum_v,
  output logic [X-1:0] carry_v
);
  localparam int CW = X + 2;

  // One independent cell per column, with no link between columns
  for (genvar i = 0; i < X; i++) begin : g_col
    csa_fa_cell u_cell (
      .bit_a (in0[i]),
      .bit_b (in1[i]),
      .bit_c (in2[i]),
      .bit_s (sum_v[i]),
      .bit_co(carry_v[i])
    );
  end

  // R2/R4: row keeps the weighted total, with carry column i worth 2^(i+1)
  always_comb begin
    a_r4_row_balance: assert ({2'b00, in0} + {2'b00, in1} + {2'b00, in2}
                              == CW'({2'b00, sum_v}) + CW'({1'b0, carry_v, 1'b0}))
      else $error("R4 row weight mismatch");
  end
endmodule

// File: rtl/csa_cpa.sv
module csa_cpa #(
  parameter int X = 6
) (
  input  logic [X-1:0] opa,
  input  logic [X-1:0] opb,
  output logic [X-1:0] res,
  output logic         cout
);
  logic [X:0] chain;

  assign chain[0] = 1'b0;

  for (genvar i = 0; i < X; i++) begin : g_rip
    csa_fa_cell u_cell (
      .bit_a (opa[i]),
      .bit_b (opb[i]),
      .bit_c (chain[i]),
      .bit_s (res[i]),
      .bit_co(chain[i+1])
    );
  end

  assign cout = chain[X];

  // R6: the ripple chain yields the two-operand sum with a zero carry-in
  always_comb begin
    a_r6_cpa_sum: assert ({cout, res} == {1'b0, opa} + {1'b0, opb})
      else $error("R6 carry-propagate sum mismatch");
  end
endmodule

// File: rtl/csa_quad_adder.sv
module csa_quad_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0]   in_w,
  input  logic [W-1:0]   in_x,
  input  logic [W-1:0]   in_y,
  input  logic [W-1:0]   in_z,
  output logic [W+1:0]   total
);
  localparam int X = W + 2;

  // Zero-extended operands
  logic [X-1:0] ext_w, ext_x, ext_y, ext_z;
  assign ext_w = X'(in_w);
  assign ext_x = X'(in_x);
  assign ext_y = X'(in_y);
  assign ext_z = X'(in_z);

  // Named internal vectors
  logic [X-1:0] row1_sum, row1_carry, row1_carry_sh;
  logic [X-1:0] row2_sum, row2_carry, row2_carry_sh;
  logic         final_cout;

  // R3: first row takes three operands
  csa_row #(.X(X)) u_row1 (
    .in0    (ext_w),
    .in1    (ext_x),
    .in2    (ext_y),
    .sum_v  (row1_sum),
    .carry_v(row1_carry)
  );

  // R4: carry column i moves to column i+1
  assign row1_carry_sh = {row1_carry[X-2:0], 1'b0};

  // R3: second row takes the first row's result and the fourth operand
  csa_row #(.X(X)) u_row2 (
    .in0    (row1_sum),
    .in1    (row1_carry_sh),
    .in2    (ext_z),
    .sum_v  (row2_sum),
    .carry_v(row2_carry)
  );

  assign row2_carry_sh = {row2_carry[X-2:0], 1'b0};

  // R6: single carry-propagate adder
  csa_cpa #(.X(X)) u_cpa (
    .opa (row2_sum),
    .opb (row2_carry_sh),
    .res (total),
    .cout(final_cout)
  );

  // R5: no weight is shifted out or carried past the top bit
  always_comb begin
    a_r5_row1_top: assert (row1_carry[X-1] == 1'b0)
      else $error("R5 row1 carry lost");
    a_r5_row2_top: assert (row2_carry[X-1] == 1'b0)
      else $error("R5 row2 carry lost");
    a_r5_cpa_cout: assert (final_cout == 1'b0)
      else $error("R5 final carry-out lost");
  end

  // R1: end-to-end sum equals the operand total
  always_comb begin
    a_r1_total: assert (total == X'(ext_w) + X'(ext_x) + X'(ext_y) + X'(ext_z))
      else $error("R1 total mismatch");
  end
endmodule

// File: tb/csa_quad_adder_bench.sv
module csa_quad_adder_bench;
  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic [W-1:0] in_w, in_x, in_y, in_z;
  logic [W+1:0] total;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  csa_quad_adder #(.W(W)) u_csa_quad_adder (
    .in_w (in_w),
    .in_x (in_x),
    .in_y (in_y),
    .in_z (in_z),
    .total(total)
  );

  task automatic check(input string req, input int expv);
    checks++;
    if (int'(total) != expv) begin
      fails++;
      $display("FAIL %s: w=%0d x=%0d y=%0d z=%0d got %0d expected %0d",
               req, in_w, in_x, in_y, in_z, total, expv);
    end
  endtask

  initial begin
    in_w = '0; in_x = '0; in_y = '0; in_z = '0;
    @(negedge clk);
    check("R8", 0);                                  // R8 all-zero case
    for (int w = 0; w <= MAXV; w++)
      for (int x = 0; x <= MAXV; x++)
        for (int y = 0; y <= MAXV; y++)
          for (int z = 0; z <= MAXV; z++) begin
            @(posedge clk);
            in_w = W'(w); in_x = W'(x); in_y = W'(y); in_z = W'(z);
            @(negedge clk);
            if (w == MAXV && x == MAXV && y == MAXV && z == MAXV)
              check("R7", 4 * MAXV);                 // R7 maximum case
            else if (w + x + y + z == 0)
              check("R8", 0);
            else if ((x + y + z == 0) || (w + y + z == 0) ||
                     (w + x + z == 0) || (w + x + y == 0))
              check("R3", w + x + y + z);            // R3 single operand
            else if (w == x && x == y)
              check("R4", w + x + y + z);            // R4 row1 carries all set
            else if ((w & x & y) != 0)
              check("R2", w + x + y + z);            // R2 majority columns
            else if (z == MAXV)
              check("R6", w + x + y + z);            // R6 long ripple
            else if (((w ^ x ^ y) & z) != 0)
              check("R5", w + x + y + z);            // R5 upper carries
            else
              check("R1", w + x + y + z);            // R1 general
          end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule